// File: doc/BRIEF.md
# Serial Audio Link Output Frame Serializer

This block is the transmit side of a controller that talks to an audio codec over a fixed-rate serial link. It runs on the link bit clock. It produces a frame marker (`sync`) and a single serial data line (`sdata_out`). Each frame lasts 256 bit periods. A 16-bit tag slot comes first. It announces which of the twelve following 20-bit data slots carry payload and which codec the frame addresses. With a 12.288 MHz bit clock, the frame rate is a fixed 48 kHz. Streams at lower sample rates are carried by marking slots invalid in frames that have no sample.

The host presents all twelve slot words, their valid flags, a per-slot meaningful-width field and a 2-bit codec identifier on a parallel interface. The block copies them into a shadow register on the clock edge that starts a frame. On that same edge it raises `frame_ready` for one cycle, so the host can prepare the next frame. The serializer then shifts the copy out MSB first. It writes zeros into every position of an invalid slot and into the unused low-order positions of a narrow slot.

Sequencing uses a three-state machine:
- `ST_IDLE` is entered on reset. On the first clock after reset it takes the transition *start* to `ST_TAG`.
- `ST_TAG` counts down the sixteen tag bits. It takes *tag_done* to `ST_DATA`.
- `ST_DATA` walks slot by slot and bit by bit. It takes *next_slot* (staying in `ST_DATA`) at the end of each slot other than the last. At the end of slot 12 it takes *wrap* back to `ST_TAG`. That wrap edge is also the start of the next frame.

Top module: `ac_out_framer`

## Requirements
- R1: `sync` rises exactly once every 256 clock cycles once the block is out of reset, and `frame_ready` is high for exactly one cycle in each frame, on the same edge that raises `sync`.
- R2: `sync` stays high for 16 consecutive cycles and then low for 240.
- R3: The first tag bit appears on `sdata_out` one clock edge after the edge that raises `sync`. One further bit follows on each rising edge, each slot MSB first: 16 tag bits, then slots 1 to 12 in order.
- R4: Tag bit 15 (the first bit sent) is 1 when any bit of `slot_valid` captured for the frame is 1, and 0 otherwise.
- R5: Tag bits 14 down to 3 carry `slot_valid[0]` (slot 1) down to `slot_valid[11]` (slot 12). Tag bit 2 is always 0.
- R6: Tag bits 1:0 carry the captured `codec_id`.
- R7: Slot k+1 sends `slot_data[k*20 +: 20]`, bit 19 first.
- R8: A slot whose valid flag is 0 sends twenty 0 bits, whatever its data.
- R9: `slot_width[k*5 +: 5]` is the meaningful width w of slot k+1. For w from 1 to 19, only the top w bits are sent as given and the 20-w trailing bits are sent as 0. For w = 0 or w ≥ 20, all 20 bits are sent.
- R10: All inputs are sampled only on the edge that raises `sync`. Changes made at any other time have no effect on the frame being sent.
- R11: While `rst` is high at a clock edge, `sync`, `sdata_out` and `frame_ready` are driven low. On the first edge with `rst` low, a new frame starts: `sync` and `frame_ready` rise and the inputs are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| codec_id | input | 2 | Target codec identifier placed in tag bits 1:0 |
| slot_valid | input | 12 | Valid flag per data slot, bit k for slot k+1 |
| slot_data | input | 240 | Slot words, bits k*20 +: 20 for slot k+1 |
| slot_width | input | 60 | Meaningful width per slot, bits k*5 +: 5 for slot k+1 |
| frame_ready | output | 1 | One-cycle pulse: inputs just captured, next frame may be loaded |
| sync | output | 1 | Frame marker, high during the tag slot period |
| sdata_out | output | 1 | Serial frame data, MSB first |

## Verification
A slip in the slot or bit counters shows up on `sdata_out` within the same frame: a slot word appears shifted or spread across two slots. A wrong wrap point also moves the next `sync` rise away from its 256-cycle spacing, one frame later at most. A shadow register that follows the inputs outside the capture edge is exposed by rewriting every input right after `frame_ready`, which corrupts the frame still being sent. A masking fault shows as stray ones in the trailing positions of a narrow slot or inside an invalid slot, visible in the very slot concerned.

// File: rtl/ac_out_pkg.sv
package ac_out_pkg;

    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int NUM_SLOTS  = 12;
    localparam int WIDTH_BITS = 5;
    localparam int ID_BITS    = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2
    } tx_state_e;

endpackage

// File: rtl/ac_out_slot_mask.sv
module ac_out_slot_mask #(
    parameter int SLOT_W = 20,
    parameter int WID_W  = 5
) (
    input  logic [SLOT_W-1:0] data,
    input  logic [WID_W-1:0]  width,
    input  logic              valid,
    output logic [SLOT_W-1:0] word
);

    int w_eff;

    // Keep the top w bits of a valid slot; zero and out-of-range widths mean full.
    always_comb begin
        w_eff = int'(width);
        word  = '0;
        if (valid) begin
            for (int j = 0; j < SLOT_W; j++) begin
                if (w_eff == 0 || w_eff >= SLOT_W || j >= SLOT_W - w_eff) begin
                    word[j] = data[j];
                end
            end
        end
    end

endmodule

// File: rtl/ac_out_tag_enc.sv
module ac_out_tag_enc #(
    parameter int NS    = 12,
    parameter int TAG_W = 16,
    parameter int ID_W  = 2
) (
    input  logic [NS-1:0]    valid,
    input  logic [ID_W-1:0]  id,
    output logic [TAG_W-1:0] tag
);

    // MSB: any slot valid; then one flag per slot, slot 1 first; spare bit 0; id last.
    always_comb begin
        tag = '0;
        tag[TAG_W-1] = |valid;
        for (int k = 0; k < NS; k++) begin
            tag[TAG_W-2-k] = valid[k];
        end
        tag[ID_W-1:0] = id;
    end

endmodule

// File: rtl/ac_out_shadow.sv
module ac_out_shadow #(
    parameter int NS     = 12,
    parameter int SLOT_W = 20,
    parameter int WID_W  = 5,
    parameter int ID_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [NS*SLOT_W-1:0] data_in,
    input  logic [NS-1:0]        valid_in,
    input  logic [NS*WID_W-1:0]  width_in,
    input  logic [ID_W-1:0]      id_in,
    output logic [NS*SLOT_W-1:0] words_q,
    output logic [NS-1:0]        valid_q,
    output logic [ID_W-1:0]      id_q
);

    logic [NS*SLOT_W-1:0] masked;

    for (genvar k = 0; k < NS; k++) begin : g_mask
        ac_out_slot_mask #(
            .SLOT_W(SLOT_W),
            .WID_W (WID_W)
        ) u_mask (
            .data (data_in[k*SLOT_W +: SLOT_W]),
            .width(width_in[k*WID_W +: WID_W]),
            .valid(valid_in[k]),
            .word (masked[k*SLOT_W +: SLOT_W])
        );

        // R8
        invalid_slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !valid_q[k] |-> (words_q[k*SLOT_W +: SLOT_W] == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
            valid_q <= '0;
            id_q    <= '0;
        end else if (load) begin
            words_q <= masked;
            valid_q <= valid_in;
            id_q    <= id_in;
        end
    end

    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(words_q) && $stable(valid_q) && $stable(id_q)));

endmodule

// File: rtl/ac_out_framer.sv
module ac_out_framer
    import ac_out_pkg::*;
#(
    parameter int NUM_SLOTS_P  = NUM_SLOTS,
    parameter int SLOT_BITS_P  = SLOT_BITS,
    parameter int TAG_BITS_P   = TAG_BITS,
    parameter int WIDTH_BITS_P = WIDTH_BITS,
    parameter int ID_BITS_P    = ID_BITS
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [ID_BITS_P-1:0]              codec_id,
    input  logic [NUM_SLOTS_P-1:0]            slot_valid,
    input  logic [NUM_SLOTS_P*SLOT_BITS_P-1:0] slot_data,
    input  logic [NUM_SLOTS_P*WIDTH_BITS_P-1:0] slot_width,
    output logic                              frame_ready,
    output logic                              sync,
    output logic                              sdata_out
);

    localparam int CNT_W      = $clog2((SLOT_BITS_P > TAG_BITS_P) ? SLOT_BITS_P : TAG_BITS_P);
    localparam int TAG_IDX_W  = $clog2(TAG_BITS_P);
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS_P);
    localparam int RUN_W      = CNT_W + 1;

    tx_state_e               state_q, state_d;
    logic [CNT_W-1:0]        bit_q, bit_d;
    logic [SLOT_IDX_W-1:0]   slot_q, slot_d;
    logic                    frame_start;
    logic                    sync_d, tx_d;
    logic                    sync_q, sdata_q, ready_q;

    logic [NUM_SLOTS_P*SLOT_BITS_P-1:0] shadow_words;
    logic [NUM_SLOTS_P-1:0]             shadow_valid;
    logic [ID_BITS_P-1:0]               shadow_id;
    logic [TAG_BITS_P-1:0]              tag_word;
    logic [SLOT_BITS_P-1:0]             slot_words [NUM_SLOTS_P];

    ac_out_shadow #(
        .NS    (NUM_SLOTS_P),
        .SLOT_W(SLOT_BITS_P),
        .WID_W (WIDTH_BITS_P),
        .ID_W  (ID_BITS_P)
    ) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .load    (frame_start),
        .data_in (slot_data),
        .valid_in(slot_valid),
        .width_in(slot_width),
        .id_in   (codec_id),
        .words_q (shadow_words),
        .valid_q (shadow_valid),
        .id_q    (shadow_id)
    );

    ac_out_tag_enc #(
        .NS   (NUM_SLOTS_P),
        .TAG_W(TAG_BITS_P),
        .ID_W (ID_BITS_P)
    ) u_tag (
        .valid(shadow_valid),
        .id   (shadow_id),
        .tag  (tag_word)
    );

    for (genvar k = 0; k < NUM_SLOTS_P; k++) begin : g_unpack
        assign slot_words[k] = shadow_words[k*SLOT_BITS_P +: SLOT_BITS_P];
    end

    // Next-state logic: start, tag_done, next_slot, wrap.
    always_comb begin
        state_d     = state_q;
        bit_d       = bit_q;
        slot_d      = slot_q;
        frame_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d     = ST_TAG;
                bit_d       = CNT_W'(TAG_BITS_P - 1);
                slot_d      = '0;
                frame_start = 1'b1;
            end
            ST_TAG: begin
                if (bit_q == '0) begin
                    state_d = ST_DATA;
                    bit_d   = CNT_W'(SLOT_BITS_P - 1);
                    slot_d  = '0;
                end else begin
                    bit_d = bit_q - CNT_W'(1);
                end
            end
            ST_DATA: begin
                if (bit_q == '0) begin
                    if (slot_q == SLOT_IDX_W'(NUM_SLOTS_P - 1)) begin
                        state_d     = ST_TAG;
                        bit_d       = CNT_W'(TAG_BITS_P - 1);
                        slot_d      = '0;
                        frame_start = 1'b1;
                    end else begin
                        slot_d = slot_q + SLOT_IDX_W'(1);
                        bit_d  = CNT_W'(SLOT_BITS_P - 1);
                    end
                end else begin
                    bit_d = bit_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output selection per state.
    always_comb begin
        sync_d = 1'b0;
        tx_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                sync_d = 1'b1;
                tx_d   = 1'b0;
            end
            ST_TAG: begin
                sync_d = (bit_q != '0);
                tx_d   = tag_word[bit_q[TAG_IDX_W-1:0]];
            end
            ST_DATA: begin
                sync_d = frame_start;
                tx_d   = slot_words[slot_q][bit_q];
            end
            default: begin
                sync_d = 1'b0;
                tx_d   = 1'b0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            slot_q  <= slot_d;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 1'b0;
            sdata_q <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            sync_q  <= sync_d;
            sdata_q <= tx_d;
            ready_q <= frame_start;
        end
    end

    assign sync        = sync_q;
    assign sdata_out   = sdata_q;
    assign frame_ready = ready_q;

    // Run length of the frame marker, kept for the checks below.
    logic [RUN_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (sync_q) begin
            hi_run <= hi_run + RUN_W'(1);
        end else begin
            hi_run <= '0;
        end
    end

    // R2
    sync_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sync) |-> (hi_run == RUN_W'(TAG_BITS_P)));

    // R1
    ready_align_chk: assert property (@(posedge clk) disable iff (rst)
        frame_ready |-> $rose(sync));

    // R1
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_ready |=> !frame_ready);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sync && !sdata_out && !frame_ready));

endmodule

// File: tb/sim_ac_out_framer.sv
module sim_ac_out_framer;

    localparam int CLK_PERIOD = 10;
    localparam int NS   = 12;
    localparam int SW   = 20;
    localparam int WW   = 5;
    localparam int FBIT = 256;
    localparam int WATCHDOG = 50000;

    typedef struct packed {
        logic [11:0] valid;
        logic [1:0]  id;
        logic [19:0] dbase;
        logic [4:0]  wbase;
        logic [4:0]  wstep;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{12'hFFF, 2'd0, 20'hABCDE, 5'd20, 5'd0},
        '{12'h000, 2'd1, 20'h5A5A5, 5'd20, 5'd0},
        '{12'h001, 2'd2, 20'h13579, 5'd0,  5'd0},
        '{12'h800, 2'd3, 20'hFFFFF, 5'd1,  5'd0},
        '{12'hA5A, 2'd1, 20'h2468A, 5'd0,  5'd3},
        '{12'hFFF, 2'd0, 20'hFFFFF, 5'd19, 5'd1},
        '{12'h3F0, 2'd2, 20'h12345, 5'd5,  5'd7}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [1:0]     codec_id = '0;
    logic [NS-1:0]  slot_valid = '0;
    logic [NS*SW-1:0] slot_data = '0;
    logic [NS*WW-1:0] slot_width = '0;
    logic           frame_ready, sync, sdata_out;

    int checks = 0;
    int fails  = 0;

    ac_out_framer u0 (
        .clk        (clk),
        .rst        (rst),
        .codec_id   (codec_id),
        .slot_valid (slot_valid),
        .slot_data  (slot_data),
        .slot_width (slot_width),
        .frame_ready(frame_ready),
        .sync       (sync),
        .sdata_out  (sdata_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [19:0] data_of(vec_t v, int s);
        return v.dbase + 20'(s) * 20'h0F1E3;
    endfunction

    function automatic logic [4:0] width_of(vec_t v, int s);
        return v.wbase + 5'(s) * v.wstep;
    endfunction

    function automatic logic [19:0] exp_slot(vec_t v, int s);
        logic [19:0] d;
        int w;
        d = data_of(v, s);
        w = int'(width_of(v, s));
        if (!v.valid[s]) return 20'h0;
        if (w == 0 || w >= 20) return d;
        return d & ~((20'h1 << (20 - w)) - 20'h1);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_vec(input vec_t v);
        codec_id   = v.id;
        slot_valid = v.valid;
        for (int s = 0; s < NS; s++) begin
            slot_data[s*SW +: SW]  = data_of(v, s);
            slot_width[s*WW +: WW] = width_of(v, s);
        end
    endtask

    task automatic drive_noise();
        codec_id   = ~codec_id;
        slot_valid = ~slot_valid;
        slot_data  = ~slot_data;
        slot_width = '0;
    endtask

    task automatic run_frame(input vec_t v, input int idx);
        logic [FBIT-1:0] got;
        logic [FBIT-1:0] sy;
        logic [FBIT-1:0] exp_sy;
        logic [15:0]     exp_tag;
        int              rdy_bad;
        drive_vec(v);
        do @(negedge clk); while (!frame_ready);
        // R10: rewrite every input right after capture
        drive_noise();
        rdy_bad = 0;
        for (int i = 0; i < FBIT; i++) begin
            @(negedge clk);
            got[FBIT-1-i] = sdata_out;
            sy[FBIT-1-i]  = sync;
            if (frame_ready != (i == FBIT-1)) rdy_bad++;
        end
        for (int i = 0; i < FBIT; i++) exp_sy[FBIT-1-i] = (i < 15) || (i == FBIT-1);
        check(sy == exp_sy, $sformatf("R1/R2 sync shape vec%0d", idx),
              64'(sy[FBIT-1 -: 64]), 64'(exp_sy[FBIT-1 -: 64]));
        check(rdy_bad == 0, $sformatf("R1 ready pulse vec%0d", idx), 64'(rdy_bad), 64'd0);
        exp_tag = {|v.valid, 12'h0, 1'b0, v.id};
        for (int k = 0; k < NS; k++) exp_tag[14-k] = v.valid[k];
        check(got[255] == exp_tag[15], $sformatf("R3/R4 frame valid vec%0d", idx),
              64'(got[255]), 64'(exp_tag[15]));
        check(got[254:242] == exp_tag[14:2], $sformatf("R5 slot flags vec%0d", idx),
              64'(got[254:242]), 64'(exp_tag[14:2]));
        check(got[241:240] == exp_tag[1:0], $sformatf("R6 codec id vec%0d", idx),
              64'(got[241:240]), 64'(exp_tag[1:0]));
        for (int s = 0; s < NS; s++) begin
            check(got[239-20*s -: 20] == exp_slot(v, s),
                  $sformatf("R7/R8/R9/R10 slot%0d vec%0d", s+1, idx),
                  64'(got[239-20*s -: 20]), 64'(exp_slot(v, s)));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: quiet outputs during reset
        check(!sync && !sdata_out && !frame_ready, "R11 reset outputs",
              {61'd0, sync, sdata_out, frame_ready}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(sync && frame_ready, "R11 first edge starts frame",
              {62'd0, sync, frame_ready}, 64'd3);

        for (int n = 0; n < NVEC; n++) run_frame(VECS[n], n);

        // R11: reset in the middle of the data slots
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!sync && !sdata_out && !frame_ready, "R11 mid-frame reset",
              {61'd0, sync, sdata_out, frame_ready}, 64'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sync && frame_ready, "R11 restart after reset",
              {62'd0, sync, frame_ready}, 64'd3);
        run_frame(VECS[4], 40);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule